// File: doc/BRIEF.md
# Pipelined ADC command sequencer

This block runs the command stream of a single ADC. A two-slot queue takes commands over a valid/ready handshake. A new command always enters the tail slot. Whenever the head slot is empty, or the head command finishes, the tail command moves up to the head. Commands run strictly in the order they arrived.

There are two kinds of command:

- A **configuration** command is a register access. It occupies the sequencer for a fixed time and may only start once it sits in the head slot.
- A **conversion** command selects an analog channel and sets a sampling length in ADC clocks.

For each conversion, the sequencer:

- drives the multiplexer channel select,
- raises a sample-phase strobe, then a convert-phase strobe,
- latches an external time-base count when sampling ends,
- pulses a result strobe carrying the channel, a placeholder result and that timestamp.

The converter itself is a stub of fixed length. One ADC clock spans `DIV` system clocks, where `DIV` is even.

Back-to-back conversions are overlapped. If the tail slot holds a conversion while the head conversion is converting, that tail channel appears on the multiplexer select half an ADC clock before the conversion phase ends. Its sampling then starts on the very next cycle. This lengthens the settling time of the multiplexer and gives a steady result rate.

The controller has four states:

| State | Meaning |
|-------|---------|
| IDLE | Nothing is executing. |
| CFG | A configuration command is running. |
| SAMPLE | A conversion is sampling. |
| CONVERT | A conversion is converting. |

Its transitions are:

- **start-config:** IDLE to CFG, when the head slot holds a configuration command.
- **start-sample:** IDLE to SAMPLE, when the head slot holds a conversion command.
- **config-done:** CFG to IDLE, after `CFG_CYC*DIV` cycles.
- **sample-done:** SAMPLE to CONVERT, after the sampling length.
- **convert-to-idle:** CONVERT to IDLE, after `CONV_CYC*DIV` cycles, when the tail slot holds no conversion.
- **convert-chain:** CONVERT to SAMPLE, after `CONV_CYC*DIV` cycles, when the tail slot holds a conversion.

Top module: `adc_cmd_seq`

## Requirements
- R1: After a synchronous reset the outputs are as follows: `cmd_ready` is 1; `mux_sel` is 0; `smp_phase`, `cnv_phase`, `cfg_active` and `res_valid` are all 0.
- R2: `cmd_ready` is 1 exactly while the tail slot is empty. Accepted commands execute, and their results appear, in arrival order.
- R3: A configuration command (`cmd_cfg`=1) raises `cfg_active` for exactly `CFG_CYC*DIV` cycles. It enters CFG only from IDLE, never overlapping a conversion.
- R4: The sample phase (`smp_phase`=1) lasts max(`cmd_smp`,2)*`DIV` system cycles. Values 0 and 1 act as 2.
- R5: The convert phase (`cnv_phase`=1) starts in the cycle after the last sample cycle. It lasts `CONV_CYC*DIV` cycles.
- R6: Suppose the tail slot holds a conversion while the head conversion is in cycle `CONV_CYC*DIV-DIV/2-1` of its convert phase. Then `mux_sel` takes the tail channel `DIV/2` cycles before that tail's `smp_phase` rises.
- R7: A conversion starting from IDLE drives its channel on `mux_sel` in its first sample cycle.
- R8: `res_ts` carries the value of `tbase` during the last sample cycle of that conversion.
- R9: `res_valid` pulses for one cycle, in the cycle after the last convert cycle. `res_chan` is the converted channel. `res_data` is that channel zero-extended to `RES_W` bits.
- R10: In a stream where a next conversion is always waiting in time, `res_valid` pulses every (max(smp,2)+`CONV_CYC`)*`DIV` cycles. Sampling starts in the cycle right after convert ends.
- R11: A reset asserted mid-conversion empties both slots and drops every phase. No result of the aborted commands appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Tail slot empty, command accepted when valid |
| cmd_cfg | input | 1 | 1 = configuration command, 0 = conversion |
| cmd_chan | input | CH_W | Channel number of a conversion |
| cmd_smp | input | SMP_W | Sampling length in ADC clocks |
| tbase | input | TB_W | Free-running time-base count |
| mux_sel | output | CH_W | Multiplexer channel select |
| smp_phase | output | 1 | Sample phase strobe |
| cnv_phase | output | 1 | Convert phase strobe |
| cfg_active | output | 1 | Configuration command executing |
| res_valid | output | 1 | Result strobe, one cycle |
| res_chan | output | CH_W | Channel of the result |
| res_data | output | RES_W | Placeholder conversion value |
| res_ts | output | TB_W | Timestamp taken at end of sampling |

## Verification
The bench builds the block with `DIV`=4, so the half-ADC-clock lead is two system cycles. This makes the early channel switch distinguishable from a switch at the start of sampling. It keeps the default 12-clock converter and 2-clock configuration time, with 4-bit sampling fields. These settings bring within reach:

- sampling lengths 0 and 1, which must clamp to 2;
- a tail conversion that arrives after the early-switch point;
- a configuration command held back behind a conversion;
- a reset that hits in the middle of a pipelined pair.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_CFG,
        SQ_SMP,
        SQ_CNV
    } sq_state_e;

endpackage

// File: rtl/adc_seq_queue.sv
module adc_seq_queue #(
    parameter int CH_W  = 5,
    parameter int SMP_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_cfg,
    input  logic [CH_W-1:0]  in_chan,
    input  logic [SMP_W-1:0] in_smp,
    input  logic             done,
    output logic             head_v,
    output logic             head_cfg,
    output logic [CH_W-1:0]  head_chan,
    output logic [SMP_W-1:0] head_smp,
    output logic             tail_v,
    output logic             tail_cfg,
    output logic [CH_W-1:0]  tail_chan,
    output logic [SMP_W-1:0] tail_smp
);

    localparam int ENT_W = 1 + CH_W + SMP_W;

    logic [ENT_W-1:0] slot_q [2];
    logic [1:0]       vld_q;
    logic             take;
    logic             shift;

    assign in_ready = !vld_q[0];
    assign take     = in_valid && !vld_q[0];
    assign shift    = vld_q[0] && (!vld_q[1] || done);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q     <= '0;
            slot_q[0] <= '0;
            slot_q[1] <= '0;
        end else begin
            if (shift) begin
                slot_q[1] <= slot_q[0];
                vld_q[1]  <= 1'b1;
                vld_q[0]  <= 1'b0;
            end else if (done) begin
                vld_q[1]  <= 1'b0;
            end
            if (take) begin
                slot_q[0] <= {in_cfg, in_chan, in_smp};
                vld_q[0]  <= 1'b1;
            end
        end
    end

    assign head_v = vld_q[1];
    assign tail_v = vld_q[0];
    assign {head_cfg, head_chan, head_smp} = slot_q[1];
    assign {tail_cfg, tail_chan, tail_smp} = slot_q[0];

    // R2: a waiting tail entry is neither lost nor altered before it moves up
    assert_tail_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (tail_v && !shift) |=> (tail_v && $stable(tail_chan) && $stable(tail_cfg)));

    // R2: an accepted command closes the handshake in the next cycle
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        take |=> !in_ready);

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int CH_W     = 5,
    parameter int SMP_W    = 4,
    parameter int DIV      = 2,
    parameter int CONV_CYC = 12,
    parameter int CFG_CYC  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             head_v,
    input  logic             head_cfg,
    input  logic [CH_W-1:0]  head_chan,
    input  logic [SMP_W-1:0] head_smp,
    input  logic             tail_v,
    input  logic             tail_cfg,
    input  logic [CH_W-1:0]  tail_chan,
    input  logic [SMP_W-1:0] tail_smp,
    output logic             done,
    output logic             cap,
    output logic             fire,
    output logic [CH_W-1:0]  mux_sel,
    output logic             smp_phase,
    output logic             cnv_phase,
    output logic             cfg_active,
    output logic             res_valid,
    output logic [CH_W-1:0]  res_chan
);

    localparam int HALF     = DIV / 2;
    localparam int CONV_LEN = CONV_CYC * DIV;
    localparam int CFG_LEN  = CFG_CYC * DIV;
    localparam int MIN_SMP  = 2;
    localparam int CNT_W    = $clog2(((2 ** SMP_W) + CONV_CYC + CFG_CYC) * DIV);
    localparam logic [CNT_W-1:0] EARLY_AT = CNT_W'(CONV_LEN - HALF - 1);

    sq_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] len_q, len_d;
    logic [CH_W-1:0]  cur_q, cur_d;
    logic [CH_W-1:0]  mux_q, mux_d;
    logic [CH_W-1:0]  rch_q, rch_d;
    logic             rv_q, rv_d;
    logic             last;
    logic             tail_conv;

    function automatic logic [CNT_W-1:0] smp_len(input logic [SMP_W-1:0] s);
        if (s < SMP_W'(MIN_SMP))
            return CNT_W'(MIN_SMP * DIV);
        else
            return CNT_W'(s) * CNT_W'(DIV);
    endfunction

    assign last      = (cnt_q == len_q - CNT_W'(1));
    assign tail_conv = tail_v && !tail_cfg;

    // next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q + CNT_W'(1);
        len_d = len_q;
        cur_d = cur_q;
        mux_d = mux_q;
        rch_d = rch_q;
        rv_d  = 1'b0;
        unique case (st_q)
            SQ_IDLE: begin
                cnt_d = '0;
                if (head_v) begin
                    if (head_cfg) begin
                        st_d  = SQ_CFG;
                        len_d = CNT_W'(CFG_LEN);
                    end else begin
                        st_d  = SQ_SMP;
                        len_d = smp_len(head_smp);
                        cur_d = head_chan;
                        mux_d = head_chan;
                    end
                end
            end
            SQ_CFG: begin
                if (last) begin
                    st_d  = SQ_IDLE;
                    cnt_d = '0;
                end
            end
            SQ_SMP: begin
                if (last) begin
                    st_d  = SQ_CNV;
                    len_d = CNT_W'(CONV_LEN);
                    cnt_d = '0;
                end
            end
            SQ_CNV: begin
                if (cnt_q == EARLY_AT && tail_conv)
                    mux_d = tail_chan;
                if (last) begin
                    rv_d  = 1'b1;
                    rch_d = cur_q;
                    cnt_d = '0;
                    if (tail_conv) begin
                        st_d  = SQ_SMP;
                        len_d = smp_len(tail_smp);
                        cur_d = tail_chan;
                        mux_d = tail_chan;
                    end else begin
                        st_d  = SQ_IDLE;
                    end
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SQ_IDLE;
            cnt_q <= '0;
            len_q <= '0;
            cur_q <= '0;
            mux_q <= '0;
            rch_q <= '0;
            rv_q  <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            len_q <= len_d;
            cur_q <= cur_d;
            mux_q <= mux_d;
            rch_q <= rch_d;
            rv_q  <= rv_d;
        end
    end

    // outputs
    always_comb begin
        smp_phase  = (st_q == SQ_SMP);
        cnv_phase  = (st_q == SQ_CNV);
        cfg_active = (st_q == SQ_CFG);
        done       = last && (st_q == SQ_CFG || st_q == SQ_CNV);
        cap        = last && (st_q == SQ_SMP);
        fire       = rv_d;
        mux_sel    = mux_q;
        res_valid  = rv_q;
        res_chan   = rch_q;
    end

    // R3: configuration execution is only ever entered from idle
    assert_cfg_from_idle_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_active) |-> ($past(st_q) == SQ_IDLE));

    // R4: sampling never ends before the two-clock minimum
    assert_min_sample_R4: assert property (@(posedge clk) disable iff (rst)
        cap |-> (cnt_q >= CNT_W'(MIN_SMP * DIV - 1)));

    // R5: sampling is followed at once by conversion
    assert_conv_follows_R5: assert property (@(posedge clk) disable iff (rst)
        cap |=> cnv_phase);

    // R10: a waiting conversion starts sampling with no idle gap
    assert_no_gap_R10: assert property (@(posedge clk) disable iff (rst)
        (fire && tail_conv) |=> smp_phase);

endmodule

// File: rtl/adc_seq_tstamp.sv
module adc_seq_tstamp #(
    parameter int TB_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cap,
    input  logic            fire,
    input  logic [TB_W-1:0] tbase,
    output logic [TB_W-1:0] res_ts
);

    logic [TB_W-1:0] held_q;
    logic [TB_W-1:0] out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
            out_q  <= '0;
        end else begin
            if (cap)
                held_q <= tbase;
            if (fire)
                out_q <= held_q;
        end
    end

    assign res_ts = out_q;

endmodule

// File: rtl/adc_cmd_seq.sv
module adc_cmd_seq #(
    parameter int CH_W     = 5,
    parameter int SMP_W    = 4,
    parameter int TB_W     = 16,
    parameter int RES_W    = 12,
    parameter int DIV      = 2,
    parameter int CONV_CYC = 12,
    parameter int CFG_CYC  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic             cmd_cfg,
    input  logic [CH_W-1:0]  cmd_chan,
    input  logic [SMP_W-1:0] cmd_smp,
    input  logic [TB_W-1:0]  tbase,
    output logic [CH_W-1:0]  mux_sel,
    output logic             smp_phase,
    output logic             cnv_phase,
    output logic             cfg_active,
    output logic             res_valid,
    output logic [CH_W-1:0]  res_chan,
    output logic [RES_W-1:0] res_data,
    output logic [TB_W-1:0]  res_ts
);

    logic             head_v, head_cfg, tail_v, tail_cfg;
    logic [CH_W-1:0]  head_chan, tail_chan;
    logic [SMP_W-1:0] head_smp, tail_smp;
    logic             done, cap, fire;

    adc_seq_queue #(.CH_W(CH_W), .SMP_W(SMP_W)) u_queue (
        .clk(clk), .rst(rst),
        .in_valid(cmd_valid), .in_ready(cmd_ready),
        .in_cfg(cmd_cfg), .in_chan(cmd_chan), .in_smp(cmd_smp),
        .done(done),
        .head_v(head_v), .head_cfg(head_cfg), .head_chan(head_chan), .head_smp(head_smp),
        .tail_v(tail_v), .tail_cfg(tail_cfg), .tail_chan(tail_chan), .tail_smp(tail_smp)
    );

    adc_seq_fsm #(
        .CH_W(CH_W), .SMP_W(SMP_W), .DIV(DIV),
        .CONV_CYC(CONV_CYC), .CFG_CYC(CFG_CYC)
    ) u_fsm (
        .clk(clk), .rst(rst),
        .head_v(head_v), .head_cfg(head_cfg), .head_chan(head_chan), .head_smp(head_smp),
        .tail_v(tail_v), .tail_cfg(tail_cfg), .tail_chan(tail_chan), .tail_smp(tail_smp),
        .done(done), .cap(cap), .fire(fire),
        .mux_sel(mux_sel), .smp_phase(smp_phase), .cnv_phase(cnv_phase),
        .cfg_active(cfg_active), .res_valid(res_valid), .res_chan(res_chan)
    );

    adc_seq_tstamp #(.TB_W(TB_W)) u_tstamp (
        .clk(clk), .rst(rst), .cap(cap), .fire(fire),
        .tbase(tbase), .res_ts(res_ts)
    );

    assign res_data = RES_W'(res_chan);

    // R9: a result appears only as conversion ends
    assert_res_after_conv_R9: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ($past(cnv_phase) && !cnv_phase));

endmodule

// File: tb/adc_cmd_seq_test.sv
`timescale 1ns/1ps
module adc_cmd_seq_test;

    localparam int CH_W = 5, SMP_W = 4, TB_W = 16, RES_W = 12;
    localparam int DIV = 4, CONV_CYC = 12, CFG_CYC = 2, H = DIV / 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0, cmd_cfg = 1'b0;
    logic [CH_W-1:0]  cmd_chan = '0;
    logic [SMP_W-1:0] cmd_smp = '0;
    logic [TB_W-1:0]  tbase = '0;
    logic cmd_ready, smp_phase, cnv_phase, cfg_active, res_valid;
    logic [CH_W-1:0]  mux_sel, res_chan;
    logic [RES_W-1:0] res_data;
    logic [TB_W-1:0]  res_ts;

    adc_cmd_seq #(
        .CH_W(CH_W), .SMP_W(SMP_W), .TB_W(TB_W), .RES_W(RES_W),
        .DIV(DIV), .CONV_CYC(CONV_CYC), .CFG_CYC(CFG_CYC)
    ) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_cfg(cmd_cfg), .cmd_chan(cmd_chan), .cmd_smp(cmd_smp), .tbase(tbase),
        .mux_sel(mux_sel), .smp_phase(smp_phase), .cnv_phase(cnv_phase),
        .cfg_active(cfg_active), .res_valid(res_valid), .res_chan(res_chan),
        .res_data(res_data), .res_ts(res_ts)
    );

    always #2.5 clk = ~clk;

    int tests = 0, fails = 0, cyc = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        tbase <= tbase + 1'b1;
    end

    // behavioural reference model: slot flags, phase kind, cycles remaining
    int m_st = 0, m_rem = 0;
    int m_mux = 0, m_cur = 0, m_ts = 0;
    int m_rv = 0, m_rch = 0, m_rts = 0;
    int hv = 0, hc = 0, hch = 0, hs = 0;
    int tv = 0, tc = 0, tch = 0, tsm = 0;

    function automatic int slen(input int s);
        return ((s < 2) ? 2 : s) * DIV;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_rem = 0; m_mux = 0; m_cur = 0; m_ts = 0;
            m_rv = 0; m_rch = 0; m_rts = 0; hv = 0; tv = 0;
        end else begin
            bit fin, sh, acc;
            fin = (m_rem == 1) && (m_st == 1 || m_st == 3);
            acc = cmd_valid && (tv == 0);
            sh  = (tv != 0) && (hv == 0 || fin);
            m_rv = 0;
            case (m_st)
                0: if (hv != 0) begin
                       if (hc != 0) begin m_st = 1; m_rem = CFG_CYC * DIV; end
                       else begin m_st = 2; m_rem = slen(hs); m_cur = hch; m_mux = hch; end
                   end
                1: if (m_rem == 1) m_st = 0; else m_rem--;
                2: if (m_rem == 1) begin m_ts = tbase; m_st = 3; m_rem = CONV_CYC * DIV; end
                   else m_rem--;
                3: begin
                       if (m_rem == H + 1 && tv != 0 && tc == 0) m_mux = tch;
                       if (m_rem == 1) begin
                           m_rv = 1; m_rch = m_cur; m_rts = m_ts;
                           if (tv != 0 && tc == 0) begin
                               m_st = 2; m_rem = slen(tsm); m_cur = tch; m_mux = tch;
                           end else m_st = 0;
                       end else m_rem--;
                   end
                default: ;
            endcase
            if (sh) begin hv = 1; hc = tc; hch = tch; hs = tsm; tv = 0; end
            else if (fin) hv = 0;
            if (acc) begin tv = 1; tc = cmd_cfg; tch = cmd_chan; tsm = cmd_smp; end
        end
    end

    // per-cycle comparison and directed monitors
    int chq[$];      // channels expected at sample start, arrival order
    int rq[$];       // channels expected at results, arrival order
    int t_early = -1, t_res = -1, want_gap = 0;
    logic p_smp = 0, p_cnv = 0;
    logic [CH_W-1:0] p_mux = '0;

    always @(negedge clk) begin
        chk(cmd_ready == (tv == 0), "R2 ready", cmd_ready, tv == 0);
        chk(mux_sel == m_mux, "R6 mux_sel", mux_sel, m_mux);
        chk(smp_phase == (m_st == 2), "R4 smp_phase", smp_phase, m_st == 2);
        chk(cnv_phase == (m_st == 3), "R5 cnv_phase", cnv_phase, m_st == 3);
        chk(cfg_active == (m_st == 1), "R3 cfg_active", cfg_active, m_st == 1);
        chk(res_valid == m_rv, "R9 res_valid", res_valid, m_rv);
        if (!rst && res_valid) begin
            chk(res_chan == m_rch, "R9 res_chan", res_chan, m_rch);
            chk(res_data == RES_W'(m_rch), "R9 res_data", res_data, m_rch);
            chk(res_ts == m_rts, "R8 res_ts", res_ts, m_rts);
            if (rq.size() > 0) begin
                int e;
                e = rq.pop_front();
                chk(res_chan == e, "R2 result order", res_chan, e);
            end
            if (want_gap != 0 && t_res >= 0)
                chk(cyc - t_res == want_gap, "R10 result interval", cyc - t_res, want_gap);
            t_res = cyc;
        end
        if (!rst) begin
            if (cnv_phase && mux_sel != p_mux) t_early = cyc;
            if (smp_phase && !p_smp) begin
                int e;
                e = (chq.size() > 0) ? chq.pop_front() : -1;
                if (p_cnv && t_early >= 0) begin
                    chk(cyc - t_early == H, "R6 early lead", cyc - t_early, H);
                    chk(p_mux == e, "R6 channel ahead", p_mux, e);
                end else if (!p_cnv) begin
                    chk(mux_sel == e, "R7 channel at start", mux_sel, e);
                end
                t_early = -1;
            end
        end
        p_smp = smp_phase; p_cnv = cnv_phase; p_mux = mux_sel;
    end

    task automatic send(input bit cfg, input int ch, input int smp);
        bit acc;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_cfg = cfg;
        cmd_chan = CH_W'(ch); cmd_smp = SMP_W'(smp);
        acc = 0;
        while (!acc) begin
            acc = cmd_ready;
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        if (!cfg) begin chq.push_back(ch); rq.push_back(ch); end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cmd_valid = 1'b0;
        idle(2);
        rst = 1'b0;
        chq.delete(); rq.delete(); t_early = -1; t_res = -1;
    endtask

    initial begin : watchdog
        wait (cyc == 100000);
        chk(0, "watchdog", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(cmd_ready == 1, "R1 ready", cmd_ready, 1);
        chk(mux_sel == 0, "R1 mux_sel", mux_sel, 0);
        chk({smp_phase, cnv_phase, cfg_active, res_valid} == 0, "R1 strobes",
            {smp_phase, cnv_phase, cfg_active, res_valid}, 0);

        // single conversion from idle, minimum sampling
        send(0, 9, 2);
        idle(100);

        // sampling fields below the minimum
        send(0, 4, 0);
        idle(100);
        send(0, 5, 1);
        idle(100);

        // pipelined stream with equal intervals
        want_gap = (3 + CONV_CYC) * DIV; t_res = -1;
        send(0, 1, 3); send(0, 2, 3); send(0, 3, 3); send(0, 17, 3);
        idle(150);
        want_gap = 0;

        // configuration behind a conversion, then a conversion
        send(0, 6, 4); send(1, 0, 0); send(0, 7, 2);
        idle(150);

        // tail conversion arriving after the early-switch point
        send(0, 10, 2);
        idle(2 * DIV + CONV_CYC * DIV - 1);
        send(0, 11, 5);
        idle(150);

        // reset in the middle of a pipelined pair
        send(0, 12, 2); send(0, 13, 2);
        idle(30);
        do_reset();
        @(negedge clk);
        chk(mux_sel == 0, "R11 mux cleared", mux_sel, 0);
        chk(cmd_ready == 1, "R11 slots empty", cmd_ready, 1);
        chk({smp_phase, cnv_phase, res_valid} == 0, "R11 phases cleared",
            {smp_phase, cnv_phase, res_valid}, 0);
        idle(120);
        chk(res_valid == 0, "R11 no stale result", res_valid, 0);

        // recovery after reset
        send(0, 30, 6);
        idle(120);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule